// File: doc/BRIEF.md
# Twenty-Line Register-Mapped GPIO Controller

This block gives software control of twenty general-purpose pins through a small 64-bit CSR bus with separate read and write strobes. Each line has its own configuration word whose only live field is an output-enable flag. The line drives when the flag is set and is an input when it is clear. A shared output latch holds the level that each enabled line drives. Software never writes that latch directly. It changes latch bits atomically through a set-mask register and a clear-mask register, so two agents that touch different lines cannot lose each other's updates.

Pin levels come back through one input data word, after a two-stage synchronizer. The configuration words sit on an 8-byte stride. The first sixteen lines occupy the bottom of the map. The remaining four lines sit in a second window at 0x100. A driver loads the latch before it sets the enable flag, so a line begins driving at the intended level.

Top module: `gpio_csr_ctrl`

## Requirements
- R1: After synchronous reset, every line is an input (`pin_oe` all zero), the output latch (`pin_out`) is zero, and `csr_rdata` is zero.
- R2: The configuration word of line n is at byte offset 8*n for n below 16, and at 0x100 + 8*(n-16) for n from 16 to 19. A write there updates the enable flag of line n only, and `pin_oe` bit n follows it from the next cycle.
- R3: Bit 0 of a configuration word is the output-enable flag. Writing zero makes the line an input. Bits 1 to 63 are ignored on write and read back as zero, and a read returns the stored flag in bit 0.
- R4: A write to offset 0x88 sets every latch bit whose mask bit is 1 and leaves the others alone. Mask bits 20 to 63 are ignored. `pin_out` bit n always carries latch bit n, which the line drives while its enable flag is set.
- R5: A write to offset 0x90 clears every latch bit whose mask bit is 1 and leaves the others alone. Mask bits 20 to 63 are ignored.
- R6: A read at offset 0x80 returns the synchronized pin levels in bits 0 to 19, with bit n for line n, and zero above bit 19. A level that is present at `pin_in` before clock edge k is returned by a read strobed at edge k+2 or later. Reads strobed at edges k and k+1 still return the old level.
- R7: Read data appears on `csr_rdata` one cycle after the read strobe. In a cycle that follows no read strobe, `csr_rdata` is zero.
- R8: Reads from unmapped or misaligned offsets return zero, and writes to them change neither `pin_oe` nor `pin_out`. The set-mask and clear-mask offsets read back as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Write strobe, one cycle per access |
| csr_rd | input | 1 | Read strobe, one cycle per access |
| csr_addr | input | 12 | Byte offset of the access |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Read data, registered |
| pin_in | input | 20 | Asynchronous pin levels |
| pin_out | output | 20 | Output latch value per line |
| pin_oe | output | 20 | Output enable per line |

## Verification
Configuration and latch writes take effect at the clock edge that samples the write strobe. The bench drives every strobe on a falling edge and checks `pin_oe` and `pin_out` at the next falling edge. Read data is registered at the edge that samples the read strobe, so the bench reads `csr_rdata` half a cycle after that edge. After a change on `pin_in`, the bench issues three back-to-back reads and expects the old level, the old level again, and then the new level, which follows the two synchronizer stages. To show that an idle cycle clears the read data, one extra cycle with no strobe is inserted after a read of a nonzero value.

// File: rtl/gpio_csr_pkg.sv
package gpio_csr_pkg;

    localparam int CSR_AW       = 12;
    localparam int CSR_DW       = 64;
    localparam int GPIO_LINES   = 20;
    localparam int CFG_LO_LINES = 16;
    localparam int CFG_HI_BASE  = 'h100;
    localparam int OFF_RXDAT    = 'h80;
    localparam int OFF_SET      = 'h88;
    localparam int OFF_CLR      = 'h90;
    localparam int LINE_IDX_W   = 8;

    typedef enum logic [2:0] {
        ACC_NONE  = 3'd0,
        ACC_CFG   = 3'd1,
        ACC_RXDAT = 3'd2,
        ACC_SET   = 3'd3,
        ACC_CLR   = 3'd4
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e               kind;
        logic [LINE_IDX_W-1:0]   line;
    } acc_dec_t;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_csr_pkg::*;
#(
    parameter int AW        = CSR_AW,
    parameter int NUM_LINES = GPIO_LINES,
    parameter int LO_LINES  = CFG_LO_LINES,
    parameter int HI_BASE   = CFG_HI_BASE
) (
    input  logic [AW-1:0] addr,
    output acc_dec_t      dec
);

    localparam int             HI_LINES = NUM_LINES - LO_LINES;
    localparam logic [AW-1:0]  LO_END   = AW'(LO_LINES * 8);
    localparam logic [AW-1:0]  HI_START = AW'(HI_BASE);
    localparam logic [AW-1:0]  HI_END   = AW'(HI_BASE + HI_LINES * 8);
    localparam logic [AW-1:0]  A_RXDAT  = AW'(OFF_RXDAT);
    localparam logic [AW-1:0]  A_SET    = AW'(OFF_SET);
    localparam logic [AW-1:0]  A_CLR    = AW'(OFF_CLR);

    logic [AW-1:0] hi_off;

    always_comb begin
        dec.kind = ACC_NONE;
        dec.line = '0;
        hi_off   = addr - HI_START;
        if (addr[2:0] == 3'b000) begin
            if (addr < LO_END) begin
                dec.kind = ACC_CFG;
                dec.line = LINE_IDX_W'(addr >> 3);
            end else if (addr >= HI_START && addr < HI_END) begin
                dec.kind = ACC_CFG;
                dec.line = LINE_IDX_W'(LO_LINES) + LINE_IDX_W'(hi_off >> 3);
            end else if (addr == A_RXDAT) begin
                dec.kind = ACC_RXDAT;
            end else if (addr == A_SET) begin
                dec.kind = ACC_SET;
            end else if (addr == A_CLR) begin
                dec.kind = ACC_CLR;
            end
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = gpio_csr_pkg::GPIO_LINES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stable_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_in;
            stable_q <= meta_q;
        end
    end

    assign sync_out = stable_q;

endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank
    import gpio_csr_pkg::*;
#(
    parameter int NUM_LINES = GPIO_LINES,
    parameter int DW        = CSR_DW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  acc_dec_t             dec,
    input  logic [DW-1:0]        wdata,
    output logic [NUM_LINES-1:0] oe,
    output logic [NUM_LINES-1:0] out,
    output logic                 cfg_bit
);

    logic [NUM_LINES-1:0] oe_q;
    logic [NUM_LINES-1:0] out_q;
    logic [NUM_LINES-1:0] line_hit;
    logic [NUM_LINES-1:0] cfg_we;
    logic [NUM_LINES-1:0] wmask;
    logic                 set_we;
    logic                 clr_we;

    assign wmask  = wdata[NUM_LINES-1:0];
    assign set_we = wr && (dec.kind == ACC_SET);
    assign clr_we = wr && (dec.kind == ACC_CLR);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assign line_hit[i] = (dec.kind == ACC_CFG) && (dec.line == LINE_IDX_W'(i));
        assign cfg_we[i]   = wr && line_hit[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q <= '0;
        end else begin
            oe_q <= (oe_q & ~cfg_we) | (cfg_we & {NUM_LINES{wdata[0]}});
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else if (set_we) begin
            out_q <= out_q | wmask;
        end else if (clr_we) begin
            out_q <= out_q & ~wmask;
        end
    end

    assign cfg_bit = |(oe_q & line_hit);
    assign oe      = oe_q;
    assign out     = out_q;

    AST_SET_FORCES_ONES: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((out_q & $past(wmask)) == $past(wmask))); // R4
    AST_CLR_FORCES_ZEROS: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((out_q & $past(wmask)) == '0)); // R5
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(set_we || clr_we) |=> $stable(out_q)); // R8
    AST_OE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(wr && dec.kind == ACC_CFG) |=> $stable(oe_q)); // R2

endmodule

// File: rtl/gpio_csr_ctrl.sv
module gpio_csr_ctrl
    import gpio_csr_pkg::*;
#(
    parameter int AW        = CSR_AW,
    parameter int DW        = CSR_DW,
    parameter int NUM_LINES = GPIO_LINES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 csr_wr,
    input  logic                 csr_rd,
    input  logic [AW-1:0]        csr_addr,
    input  logic [DW-1:0]        csr_wdata,
    output logic [DW-1:0]        csr_rdata,
    input  logic [NUM_LINES-1:0] pin_in,
    output logic [NUM_LINES-1:0] pin_out,
    output logic [NUM_LINES-1:0] pin_oe
);

    acc_dec_t             dec;
    logic [NUM_LINES-1:0] pin_sync;
    logic                 cfg_bit;
    logic [DW-1:0]        rd_val;
    logic [DW-1:0]        rdata_q;

    gpio_addr_dec #(
        .AW        (AW),
        .NUM_LINES (NUM_LINES),
        .LO_LINES  (CFG_LO_LINES),
        .HI_BASE   (CFG_HI_BASE)
    ) u_dec (
        .addr (csr_addr),
        .dec  (dec)
    );

    gpio_in_sync #(.W(NUM_LINES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_pin_bank #(.NUM_LINES(NUM_LINES), .DW(DW)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr      (csr_wr),
        .dec     (dec),
        .wdata   (csr_wdata),
        .oe      (pin_oe),
        .out     (pin_out),
        .cfg_bit (cfg_bit)
    );

    always_comb begin
        case (dec.kind)
            ACC_CFG:   rd_val = DW'(cfg_bit);
            ACC_RXDAT: rd_val = DW'(pin_sync);
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= csr_rd ? rd_val : '0;
        end
    end

    assign csr_rdata = rdata_q;

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !csr_rd |=> (csr_rdata == '0)); // R7
    AST_MASK_REGS_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (csr_rd && (dec.kind == ACC_SET || dec.kind == ACC_CLR)) |=> (csr_rdata == '0)); // R8
    AST_CFG_READ_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        (csr_rd && dec.kind == ACC_CFG) |=> (csr_rdata[DW-1:1] == '0)); // R3

endmodule

// File: tb/gpio_csr_ctrl_tb.sv
module gpio_csr_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csr_wr = 1'b0;
    logic        csr_rd = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic [19:0] pin_in = '0;
    logic [19:0] pin_out;
    logic [19:0] pin_oe;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    gpio_csr_ctrl u_dut (
        .clk       (clk),
        .rst       (rst),
        .csr_wr    (csr_wr),
        .csr_rd    (csr_rd),
        .csr_addr  (csr_addr),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] cfg_addr(input int n);
        if (n < 16) return 12'(8 * n);
        return 12'('h100 + 8 * (n - 16));
    endfunction

    task automatic bus_wr(input logic [11:0] a, input logic [63:0] d);
        csr_addr = a; csr_wdata = d; csr_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [63:0] d);
        csr_addr = a; csr_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        csr_rd = 1'b0;
        d = csr_rdata;
    endtask

    task automatic t_reset();
        logic [63:0] d;
        chk("R1 oe after reset", 64'(pin_oe), 64'h0);
        chk("R1 latch after reset", 64'(pin_out), 64'h0);
        chk("R1 rdata after reset", csr_rdata, 64'h0);
        bus_rd(12'h080, d);
        chk("R1 input word after reset", d, 64'h0);
    endtask

    task automatic t_cfg_map();
        logic [63:0] d;
        logic [19:0] exp_oe = '0;
        for (int n = 0; n < 20; n++) begin
            bus_wr(cfg_addr(n), 64'h1);
            exp_oe[n] = 1'b1;
            chk($sformatf("R2 oe map line %0d", n), 64'(pin_oe), 64'(exp_oe));
            bus_rd(cfg_addr(n), d);
            chk($sformatf("R3 cfg readback line %0d", n), d, 64'h1);
        end
        for (int n = 19; n >= 0; n--) begin
            bus_wr(cfg_addr(n), 64'h0);
            exp_oe[n] = 1'b0;
            chk($sformatf("R2 line %0d back to input", n), 64'(pin_oe), 64'(exp_oe));
        end
    endtask

    task automatic t_cfg_bits();
        logic [63:0] d;
        bus_wr(cfg_addr(3), 64'hFFFF_FFFF_FFFF_FFFE);
        chk("R3 upper bits do not enable", 64'(pin_oe), 64'h0);
        bus_rd(cfg_addr(3), d);
        chk("R3 upper bits read zero", d, 64'h0);
        bus_wr(cfg_addr(17), 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R3 bit0 enables line 17", 64'(pin_oe), 64'h2_0000);
        bus_rd(cfg_addr(17), d);
        chk("R3 readback only bit0", d, 64'h1);
        bus_wr(cfg_addr(17), 64'h0);
        chk("R3 zero write makes input", 64'(pin_oe), 64'h0);
    endtask

    task automatic t_set_clear();
        logic [63:0] d;
        bus_wr(12'h088, 64'hFFFF_F000_000A_50F0);
        chk("R4 set mask", 64'(pin_out), 64'h0_A50F0);
        bus_wr(12'h088, 64'h0000_0000_0000_0003);
        chk("R4 set keeps others", 64'(pin_out), 64'h0_A50F3);
        bus_wr(12'h088, 64'hFFFF_FFFF_FFF0_0000);
        chk("R4 high mask bits ignored", 64'(pin_out), 64'h0_A50F3);
        bus_wr(cfg_addr(1), 64'h1);
        chk("R4 enabled line drives latch", 64'({pin_oe[1], pin_out[1]}), 64'h3);
        bus_wr(cfg_addr(1), 64'h0);
        bus_wr(12'h090, 64'h0000_0000_0008_00F1);
        chk("R5 clear mask", 64'(pin_out), 64'h0_25002);
        bus_wr(12'h090, 64'hFFFF_FFFF_FFF0_0000);
        chk("R5 high mask bits ignored", 64'(pin_out), 64'h0_25002);
        bus_wr(12'h090, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R5 clear all", 64'(pin_out), 64'h0);
        bus_wr(12'h088, 64'h0_80001);
        bus_rd(12'h088, d);
        chk("R8 set register reads zero", d, 64'h0);
        bus_rd(12'h090, d);
        chk("R8 clear register reads zero", d, 64'h0);
    endtask

    task automatic t_sync();
        logic [63:0] d;
        pin_in = 20'hC_3A5E;
        bus_rd(12'h080, d);
        chk("R6 edge k still old", d, 64'h0);
        bus_rd(12'h080, d);
        chk("R6 edge k+1 still old", d, 64'h0);
        bus_rd(12'h080, d);
        chk("R6 edge k+2 new level", d, 64'h0_C3A5E);
        @(posedge clk); @(negedge clk);
        chk("R7 idle cycle rdata zero", csr_rdata, 64'h0);
        pin_in = 20'h0_0001;
        repeat (3) begin @(posedge clk); @(negedge clk); end
        bus_rd(12'h080, d);
        chk("R6 single line level", d, 64'h1);
    endtask

    task automatic t_unmapped();
        logic [63:0] d;
        logic [19:0] oe0 = pin_oe;
        logic [19:0] out0 = pin_out;
        logic [11:0] bad [6] = '{12'h084, 12'h098, 12'h120, 12'h180, 12'hFF8, 12'h00C};
        for (int i = 0; i < 6; i++) begin
            bus_wr(bad[i], 64'hFFFF_FFFF_FFFF_FFFF);
            chk($sformatf("R8 write %h leaves oe", bad[i]), 64'(pin_oe), 64'(oe0));
            chk($sformatf("R8 write %h leaves latch", bad[i]), 64'(pin_out), 64'(out0));
            bus_rd(bad[i], d);
            chk($sformatf("R8 read %h zero", bad[i]), d, 64'h0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        t_reset();
        t_cfg_map();
        t_cfg_bits();
        t_set_clear();
        t_sync();
        t_unmapped();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule